// File: doc/BRIEF.md
# Write-and-Invalidate Line Boundary Guard

This block sits on the target side of a bridge and watches posted Memory Write and Invalidate bursts. At each address phase it captures the command, the start address, a programmable line size counted in DWORDs and a two-bit mode field. It then counts DWORDs through the data phases of the burst.

With mode `2'b11` and a usable line size, the write-and-invalidate command goes out unchanged. The block also raises a disconnect request each time the burst completes an aligned cache line. In every other case a write-and-invalidate command is rewritten to plain Memory Write and no disconnect is requested. Other commands pass straight through. The posted-write FIFO, bus signalling and arbitration belong to the surrounding logic.

Top module: `mwi_line_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, `disc_req` is 0 and `cmd_out` is 4'h0.
- R2: With command 4'hF (write-and-invalidate), mode 2'b11 and a power-of-two line size, `disc_req` is 1 in the cycle after each data phase whose completion makes the DWORD address (byte address / 4) a multiple of the line size. It is 0 in every other cycle.
- R3: The DWORD offset within the line is taken from the start address. A burst that starts at offset k therefore sees its first disconnect after (line size − k) data phases.
- R4: With command 4'hF, mode 2'b11 and a power-of-two line size, `cmd_out` equals 4'hF from the cycle after the address phase.
- R5: With command 4'hF and mode 2'b00, 2'b01 or 2'b10, `cmd_out` equals 4'h7 (Memory Write) from the cycle after the address phase, and `disc_req` stays 0.
- R6: With command 4'hF, mode 2'b11 and a line size of 0 or a value that is not a power of two, `cmd_out` equals 4'h7 and `disc_req` stays 0.
- R7: Any command other than 4'hF is copied to `cmd_out` unchanged and never causes `disc_req`.
- R8: Line size and mode are sampled only at the address phase. Changes to them during the data phases have no effect on `disc_req` or `cmd_out`.
- R9: With line size 1 under R2 conditions, every data phase is followed by `disc_req`.
- R10: `cmd_out` holds its value in every cycle that does not follow an address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Address phase strobe |
| cmd_in | input | 4 | Bus command at the address phase |
| addr_in | input | ADDR_W | Start byte address at the address phase |
| data_vld | input | 1 | One data phase completed |
| line_dw | input | CLS_W | Cache line size in DWORDs |
| mode | input | 2 | Write-and-invalidate handling mode |
| disc_req | output | 1 | Target disconnect request at a line boundary |
| cmd_out | output | 4 | Command forwarded to the destination side |

## Verification
The assertions assume that `addr_vld` and `data_vld` are never high in the same cycle. They also assume that each burst begins with one address phase before any data phase. The stimulus drives every burst as one address cycle followed by data cycles, some with idle gaps, and never overlaps the two strobes. Line size and mode are changed only between bursts, except in the test for R8, which changes them on purpose in the middle of a burst.

// File: rtl/mwi_pkg.sv
package mwi_pkg;
  localparam logic [3:0] CMD_MWI = 4'hF;
  localparam logic [3:0] CMD_MW  = 4'h7;
  localparam logic [1:0] MODE_CUT = 2'b11;

  function automatic logic line_ok(input logic [7:0] n);
    return (n != '0) && ((n & (n - 8'd1)) == '0);
  endfunction

  function automatic logic [7:0] line_mask(input logic [7:0] n);
    return n - 8'd1;
  endfunction
endpackage

// File: rtl/mwi_cfg_decode.sv
module mwi_cfg_decode
  import mwi_pkg::*;
#(
  parameter int CLS_W = 8
) (
  input  logic [3:0]       cmd,
  input  logic [CLS_W-1:0] line_dw,
  input  logic [1:0]       mode,
  output logic             cut_en,
  output logic [CLS_W-1:0] mask,
  output logic [3:0]       cmd_fwd
);
  logic is_mwi, size_ok;

  always_comb begin
    is_mwi  = (cmd == CMD_MWI);
    size_ok = line_ok(8'(line_dw));
    cut_en  = is_mwi && (mode == MODE_CUT) && size_ok;
    mask    = size_ok ? CLS_W'(line_mask(8'(line_dw))) : '0;
    cmd_fwd = (is_mwi && !cut_en) ? CMD_MW : cmd;
  end
endmodule

// File: rtl/mwi_dw_counter.sv
module mwi_dw_counter #(
  parameter int CLS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CLS_W-1:0] start_ofs,
  input  logic [CLS_W-1:0] load_mask,
  input  logic             step,
  output logic             line_end
);
  logic [CLS_W-1:0] ofs, mask_q, ofs_nxt;

  always_comb ofs_nxt = (ofs + CLS_W'(1)) & mask_q;
  assign line_end = step && (ofs_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs    <= '0;
      mask_q <= '0;
    end else if (load) begin
      ofs    <= start_ofs & load_mask;
      mask_q <= load_mask;
    end else if (step) begin
      ofs    <= ofs_nxt;
    end
  end

  // R3: the offset never leaves the current line
  a_r3_ofs_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs & ~mask_q) == '0);
endmodule

// File: rtl/mwi_line_guard.sv
module mwi_line_guard
  import mwi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CLS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [3:0]        cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_vld,
  input  logic [CLS_W-1:0]  line_dw,
  input  logic [1:0]        mode,
  output logic              disc_req,
  output logic [3:0]        cmd_out
);
  logic             cut_en_d, cut_q, line_end, data_step;
  logic [CLS_W-1:0] mask_d;
  logic [3:0]       cmd_fwd_d;
  logic [CLS_W-1:0] start_ofs;

  assign start_ofs = addr_in[CLS_W+1:2];
  assign data_step = data_vld && !addr_vld;

  mwi_cfg_decode #(.CLS_W(CLS_W)) u_dec (
    .cmd(cmd_in), .line_dw(line_dw), .mode(mode),
    .cut_en(cut_en_d), .mask(mask_d), .cmd_fwd(cmd_fwd_d)
  );

  mwi_dw_counter #(.CLS_W(CLS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(addr_vld), .start_ofs(start_ofs),
    .load_mask(mask_d), .step(data_step), .line_end(line_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cut_q    <= 1'b0;
      cmd_out  <= 4'h0;
      disc_req <= 1'b0;
    end else begin
      disc_req <= cut_q && line_end;
      if (addr_vld) begin
        cut_q   <= cut_en_d;
        cmd_out <= cmd_fwd_d;
      end
    end
  end

  // R2: a disconnect only follows a data phase
  a_r2_disc_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req |-> $past(data_vld));
  // R7: a disconnect only while the forwarded command is write-and-invalidate
  a_r7_disc_only_mwi: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req |-> cmd_out == CMD_MWI);
  // R5 / R6: a rewritten command never comes with a disconnect
  a_r5_conv_no_disc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_MW) |-> !disc_req);
  // R10: the command holds outside address phases
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(cmd_out));
  // R4: a valid cut configuration keeps the command
  a_r4_keep_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && cmd_in == CMD_MWI && mode == MODE_CUT && line_ok(8'(line_dw)))
      |=> cmd_out == CMD_MWI);
endmodule

// File: tb/sim_mwi_line_guard.sv
module sim_mwi_line_guard;
  logic        clk = 0, rst_n = 0;
  logic        addr_vld = 0, data_vld = 0;
  logic [3:0]  cmd_in = 0;
  logic [31:0] addr_in = 0;
  logic [7:0]  line_dw = 0;
  logic [1:0]  mode = 0;
  logic        disc_req;
  logic [3:0]  cmd_out;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  bit checking = 0;

  int exp_cmd = 0, exp_disc = 0, dw = 0, lsz = 0, cut = 0;

  always #2.5 clk = ~clk;

  mwi_line_guard u0 (.clk(clk), .rst_n(rst_n), .addr_vld(addr_vld),
    .cmd_in(cmd_in), .addr_in(addr_in), .data_vld(data_vld),
    .line_dw(line_dw), .mode(mode), .disc_req(disc_req), .cmd_out(cmd_out));

  function automatic int pow2(input int n);
    for (int k = 0; k < 8; k++) if (n == (1 << k)) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_cmd = 0; exp_disc = 0; cut = 0; dw = 0; lsz = 0;
    end else if (addr_vld) begin
      cut = (cmd_in == 15 && mode == 3 && pow2(line_dw)) ? 1 : 0;
      exp_cmd = (cmd_in == 15 && cut == 0) ? 7 : int'(cmd_in);
      lsz = line_dw;
      dw = cut ? int'(addr_in / 4) % lsz : 0;
      exp_disc = 0;
    end else if (data_vld) begin
      dw = dw + 1;
      exp_disc = (cut != 0 && (dw % lsz) == 0) ? 1 : 0;
    end else exp_disc = 0;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) if (checking) begin
    total++;
    if (int'(disc_req) != exp_disc || int'(cmd_out) != exp_cmd) begin
      bad++;
      $display("FAIL %s disc=%0d/%0d cmd=%0h/%0h (actual/expected)",
               tag, disc_req, exp_disc, cmd_out, exp_cmd);
    end
  end

  task automatic burst(input logic [3:0] c, input logic [31:0] a,
                       input int ln, input int md, input int n, input int gap,
                       input int chg);
    @(negedge clk);
    addr_vld = 1; cmd_in = c; addr_in = a; line_dw = 8'(ln); mode = 2'(md);
    @(negedge clk);
    addr_vld = 0; cmd_in = 0; addr_in = 0;
    for (int i = 0; i < n; i++) begin
      data_vld = 1;
      if (chg != 0 && i == 1) begin line_dw = 8'd2; mode = 2'(~md); end
      @(negedge clk);
      data_vld = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; total++;
    if (disc_req !== 0 || cmd_out !== 0) begin
      bad++; $display("FAIL R1 disc=%0d cmd=%0h expected 0/0", disc_req, cmd_out);
    end
    rst_n = 1;
    checking = 1;
    tag = "R1"; @(negedge clk);
    tag = "R2 R4 aligned line 4";  burst(4'hF, 32'h100, 4, 3, 9, 0, 0);
    tag = "R2 line 8 with gaps";   burst(4'hF, 32'h200, 8, 3, 17, 1, 0);
    tag = "R3 mid-line start";     burst(4'hF, 32'h10C, 8, 3, 12, 0, 0);
    tag = "R3 offset 31 of 32";    burst(4'hF, 32'h7C, 32, 3, 35, 0, 0);
    tag = "R9 line size 1";        burst(4'hF, 32'h44, 1, 3, 5, 0, 0);
    tag = "R5 mode 00";            burst(4'hF, 32'h0, 4, 0, 9, 0, 0);
    tag = "R5 mode 01";            burst(4'hF, 32'h0, 4, 1, 9, 0, 0);
    tag = "R5 mode 10";            burst(4'hF, 32'h0, 4, 2, 9, 0, 0);
    tag = "R6 line size 0";        burst(4'hF, 32'h0, 0, 3, 6, 0, 0);
    tag = "R6 line size 6";        burst(4'hF, 32'h0, 6, 3, 13, 0, 0);
    tag = "R7 plain memory write"; burst(4'h7, 32'h0, 4, 3, 9, 0, 0);
    tag = "R7 other command";      burst(4'h6, 32'h30, 4, 3, 9, 0, 0);
    tag = "R8 cfg change mid burst"; burst(4'hF, 32'h0, 8, 3, 17, 0, 1);
    tag = "R8 cfg change convert";   burst(4'hF, 32'h0, 4, 0, 9, 0, 1);
    tag = "R10 back to back";      burst(4'hF, 32'h8, 4, 3, 3, 2, 0);
    tag = "R10 back to back";      burst(4'h2, 32'h8, 4, 3, 3, 0, 0);
    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule